// File: doc/BRIEF.md
# I2C Slave Port with Clock Stretching

This block is an I2C slave that a local host services through a small register port. It watches the open-drain SCL and SDA lines through synchronizers and finds start and stop conditions. It compares the 7-bit address in each transfer with a programmable own address. After that it shifts data bytes in or out, MSB first, and handles the acknowledge bit.

After every acknowledge clock, for the address byte and for data bytes in either direction, the slave pulls SCL low. This is a wait request to the bus master. SCL stays low until the host services the port. In a write transfer the host reads the received byte or issues a release command. In a read transfer the host writes the next byte to send, or issues a release command. The next byte starts only after that.

A 3-bit status code reports the latest bus event. A stop condition has its own code, and a stop seen in the middle of a byte abandons that byte. A receive overrun flag records when a received byte overwrote an unread one. The host clears this flag by writing 1 to it. A single interrupt output combines the event and overrun sources under per-source enables.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset both open-drain enables are 0, `irq_o` is 0, the status register (offset 2) reads 0x00 and the own-address register (offset 0) holds the `OWN_ADDR` parameter.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. An address byte whose upper 7 bits differ from the own-address register gets no acknowledge and no SCL hold.
- R3: When the address matches, the slave pulls SDA low for the acknowledge clock. Bit 0 of the address byte selects the direction: 0 means the master writes and the status code becomes 2; 1 means the master reads and the code becomes 3. The status register layout is: bits [2:0] code, bit 3 overrun, bit 4 receive buffer full, bit 5 SCL held.
- R4: On the falling SCL edge that ends any acknowledge clock, the slave releases SDA and holds SCL low. SCL stays low until a servicing access, and the slave releases it within two system clocks after that access.
- R5: In a write transfer, each data byte is taken MSB first and acknowledged. The byte is readable at offset 1, the status code becomes 4 and the buffer-full bit is set. Reading offset 1 clears buffer-full and releases SCL.
- R6: If a byte completes while buffer-full is still set, the new byte replaces the buffer contents and the overrun bit is set.
- R7: After an overrun, the next bytes are still received, acknowledged and stretched as normal.
- R8: The overrun bit clears only when the host writes 1 to status bit 3. Writing 0 there leaves it set.
- R9: A stop during a transfer sets status code 1 and releases both lines. Any partly shifted byte is discarded, so the receive buffer keeps its earlier value.
- R10: In a read transfer, a write to offset 1 releases SCL and the written byte is sent MSB first. If the master acknowledges, the code becomes 5 and SCL is held again. If the master does not acknowledge, the code becomes 6, both lines are released and there is no hold.
- R11: `irq_o` equals (enable bit 0 AND event pending) OR (enable bit 1 AND overrun), with the enables at offset 3. Every status code update sets event pending, and reading offset 2 clears it.
- R12: Writing 1 to status bit 7 releases a held SCL without touching the receive buffer or the buffer-full bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| host_addr_i | input | 2 | Register offset: 0 address, 1 data, 2 status, 3 enables |
| host_wr_i | input | 1 | Write strobe, one clock |
| host_rd_i | input | 1 | Read strobe, one clock; side effects at offsets 1 and 2 |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data for `host_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The SCL hold property assumes the master changes neither line while SCL is held low by the slave. With that assumption, the hold can end only through a host access. The stimulus keeps to it: the bench master drives SDA only in the low half of each clock, and it only ever releases SCL and waits until the line is actually high. The overrun checks assume overrun can only rise on a byte that arrives while the buffer is full. The bench creates exactly that case by releasing with the status command instead of reading the data register.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int SLV_AW = 7;
  localparam int CNT_W  = 4;
  localparam int OFS_W  = 2;

  localparam logic [OFS_W-1:0] OFS_ADDR = 2'd0;
  localparam logic [OFS_W-1:0] OFS_DATA = 2'd1;
  localparam logic [OFS_W-1:0] OFS_STAT = 2'd2;
  localparam logic [OFS_W-1:0] OFS_IEN  = 2'd3;

  localparam int STAT_OVR = 3;
  localparam int STAT_GO  = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK,
    ST_TX, ST_TACK, ST_WAIT, ST_TREL
  } eng_state_e;

  typedef enum logic [2:0] {
    CODE_IDLE    = 3'd0,
    CODE_STOP    = 3'd1,
    CODE_ADR_RX  = 3'd2,
    CODE_ADR_TX  = 3'd3,
    CODE_RX_BYTE = 3'd4,
    CODE_TX_ACK  = 3'd5,
    CODE_TX_NACK = 3'd6
  } code_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s, sda_s;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else if (g == 0) begin
        scl_ff[g] <= scl_i;
        sda_ff[g] <= sda_i;
      end else begin
        scl_ff[g] <= scl_ff[(g > 0) ? g-1 : 0];
        sda_ff[g] <= sda_ff[(g > 0) ? g-1 : 0];
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = !scl_p && scl_s;
  assign scl_fall_o = scl_p && !scl_s;
  assign start_o    = scl_p && scl_s && sda_p && !sda_s;
  assign stop_o     = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SLV_AW-1:0] own_addr_i,
  input  logic              rel_rx_i,
  input  logic              rel_tx_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              evt_valid_o,
  output code_e             evt_code_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  eng_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              tx_dir_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      tx_dir_q    <= 1'b0;
      nack_q      <= 1'b0;
      scl_oe_o    <= 1'b0;
      sda_oe_o    <= 1'b0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
      evt_valid_o <= 1'b0;
      evt_code_o  <= CODE_IDLE;
    end else begin
      byte_done_o <= 1'b0;
      evt_valid_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sh_q     <= '0;
        scl_oe_o <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        if (state_q != ST_IDLE) begin
          evt_valid_o <= 1'b1;
          evt_code_o  <= CODE_STOP;
        end
        state_q  <= ST_IDLE;
        scl_oe_o <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST) begin
              if (sh_q[BYTE_W-1:1] == own_addr_i) begin
                sda_oe_o <= 1'b1;
                tx_dir_q <= sh_q[0];
                state_q  <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall_i) begin
            sda_oe_o    <= 1'b0;
            scl_oe_o    <= 1'b1;
            evt_valid_o <= 1'b1;
            evt_code_o  <= tx_dir_q ? CODE_ADR_TX : CODE_ADR_RX;
            state_q     <= ST_WAIT;
          end
          ST_WAIT: begin
            if (tx_dir_q && rel_tx_i) begin
              sh_q     <= tx_byte_i;
              sda_oe_o <= ~tx_byte_i[BYTE_W-1];
              state_q  <= ST_TREL;
            end else if (!tx_dir_q && rel_rx_i) begin
              scl_oe_o <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_RX;
            end
          end
          // data bit set up one clock before SCL is let go
          ST_TREL: begin
            scl_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_TX;
          end
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST - 1'b1) begin
                byte_done_o <= 1'b1;
                rx_byte_o   <= {sh_q[BYTE_W-2:0], sda_i};
              end
            end else if (scl_fall_i && cnt_q == LAST) begin
              sda_oe_o <= 1'b1;
              state_q  <= ST_RACK;
            end
          end
          ST_RACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            scl_oe_o <= 1'b1;
            state_q  <= ST_WAIT;
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == LAST - 1'b1) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_TACK;
            end else begin
              sh_q     <= sh_q << 1;
              sda_oe_o <= ~sh_q[BYTE_W-2];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_TACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              evt_valid_o <= 1'b1;
              if (!nack_q) begin
                evt_code_o <= CODE_TX_ACK;
                scl_oe_o   <= 1'b1;
                state_q    <= ST_WAIT;
              end else begin
                evt_code_o <= CODE_TX_NACK;
                state_q    <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter logic [SLV_AW-1:0] OWN_ADDR = 7'h42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFS_W-1:0]  host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              evt_valid_i,
  input  code_e             evt_code_i,
  input  logic              scl_hold_i,
  output logic [SLV_AW-1:0] own_addr_o,
  output logic              rel_rx_o,
  output logic              rel_tx_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              ovr_o,
  output logic              rx_full_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] rx_buf_q, tx_buf_q;
  logic [1:0]        ien_q;
  code_e             code_q;
  logic              evt_pend_q;
  logic              data_rd, data_wr, stat_rd, stat_wr, go;

  assign data_rd = host_rd_i && host_addr_i == OFS_DATA;
  assign data_wr = host_wr_i && host_addr_i == OFS_DATA;
  assign stat_rd = host_rd_i && host_addr_i == OFS_STAT;
  assign stat_wr = host_wr_i && host_addr_i == OFS_STAT;
  assign go      = stat_wr && host_wdata_i[STAT_GO];

  assign rel_rx_o  = data_rd || go;
  assign rel_tx_o  = data_wr || go;
  assign tx_byte_o = data_wr ? host_wdata_i : tx_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_addr_o <= OWN_ADDR;
      ien_q      <= '0;
      tx_buf_q   <= '0;
      rx_buf_q   <= '0;
      rx_full_o  <= 1'b0;
      ovr_o      <= 1'b0;
      code_q     <= CODE_IDLE;
      evt_pend_q <= 1'b0;
    end else begin
      if (host_wr_i && host_addr_i == OFS_ADDR) own_addr_o <= host_wdata_i[SLV_AW-1:0];
      if (host_wr_i && host_addr_i == OFS_IEN)  ien_q      <= host_wdata_i[1:0];
      if (data_wr) tx_buf_q <= host_wdata_i;

      if (byte_done_i) begin
        rx_buf_q  <= rx_byte_i;
        rx_full_o <= 1'b1;
        if (rx_full_o && !data_rd) ovr_o <= 1'b1;
      end else if (data_rd) begin
        rx_full_o <= 1'b0;
      end
      if (stat_wr && host_wdata_i[STAT_OVR] && !(byte_done_i && rx_full_o)) ovr_o <= 1'b0;

      if (byte_done_i) begin
        code_q     <= CODE_RX_BYTE;
        evt_pend_q <= 1'b1;
      end else if (evt_valid_i) begin
        code_q     <= evt_code_i;
        evt_pend_q <= 1'b1;
      end else if (stat_rd) begin
        evt_pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (host_addr_i)
      OFS_ADDR: host_rdata_o = {{(BYTE_W-SLV_AW){1'b0}}, own_addr_o};
      OFS_DATA: host_rdata_o = rx_buf_q;
      OFS_STAT: host_rdata_o = {2'b00, scl_hold_i, rx_full_o, ovr_o, code_q};
      default:  host_rdata_o = {{(BYTE_W-2){1'b0}}, ien_q};
    endcase
  end

  assign irq_o = (ien_q[0] && evt_pend_q) || (ien_q[1] && ovr_o);
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2cs_pkg::*;
#(
  parameter logic [SLV_AW-1:0] OWN_ADDR    = 7'h42,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [OFS_W-1:0]  host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  output logic              irq_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [SLV_AW-1:0] own_addr;
  logic              rel_rx, rel_tx, byte_done, evt_valid, ovr, rx_full;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  code_e             evt_code;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2cs_engine u_engine (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .own_addr_i(own_addr), .rel_rx_i(rel_rx), .rel_tx_i(rel_tx),
    .tx_byte_i(tx_byte),
    .scl_oe_o, .sda_oe_o,
    .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .evt_valid_o(evt_valid), .evt_code_o(evt_code)
  );

  i2cs_regs #(.OWN_ADDR(OWN_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .host_addr_i, .host_wr_i, .host_rd_i, .host_wdata_i, .host_rdata_o,
    .byte_done_i(byte_done), .rx_byte_i(rx_byte),
    .evt_valid_i(evt_valid), .evt_code_i(evt_code),
    .scl_hold_i(scl_oe_o),
    .own_addr_o(own_addr), .rel_rx_o(rel_rx), .rel_tx_o(rel_tx),
    .tx_byte_o(tx_byte), .ovr_o(ovr), .rx_full_o(rx_full),
    .irq_o
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic [1:0] host_addr_i,
  input logic       host_wr_i,
  input logic       host_rd_i,
  input logic [7:0] host_wdata_i,
  input logic       ovr,
  input logic       rx_full
);
  logic go_cmd, rel_any;
  assign go_cmd  = host_wr_i && host_addr_i == 2'd2 && host_wdata_i[7];
  assign rel_any = go_cmd || ((host_rd_i || host_wr_i) && host_addr_i == 2'd1);

  // R4
  hold_until_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o && !rel_any && !$past(rel_any) |=> scl_oe_o);

  // R12
  go_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o && go_cmd |-> ##2 !scl_oe_o);

  // R4
  sda_free_at_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> !sda_oe_o);

  // R6
  ovr_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr) |-> $past(rx_full));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr && !(host_wr_i && host_addr_i == 2'd2 && host_wdata_i[3]) |=> ovr);
endmodule

bind i2c_stretch_slave i2cs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .host_addr_i(host_addr_i), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
  .host_wdata_i(host_wdata_i), .ovr(ovr), .rx_full(rx_full)
);

// File: tb/test_i2c_stretch_slave.sv
`timescale 1ns/1ps
module test_i2c_stretch_slave;
  localparam int HP = 8;
  localparam logic [6:0] MY_ADDR = 7'h5A;
  // {data byte, expected status after it}
  localparam logic [15:0] RX_VEC [5] = '{16'h00_34, 16'hFF_34, 16'hA5_34, 16'h5A_34, 16'h81_34};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic [1:0] h_addr = '0;
  logic h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0] h_wdata = '0, h_rdata;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  i2c_stretch_slave i_i2c_stretch_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .host_addr_i(h_addr), .host_wr_i(h_wr), .host_rd_i(h_rd),
    .host_wdata_i(h_wdata), .host_rdata_o(h_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic h_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic h_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    #1 d = h_rdata;
    @(negedge clk); h_rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; half();
    m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
    half();
    r = sda_bus;
    m_scl = 1'b0; half();
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half();
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(nack, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic ack, r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
    h_read(2'd2, rd); chk("R1 status", rd, 8'h00);
    h_read(2'd0, rd); chk("R1 own addr", rd, 8'h42);

    // R2 address mismatch
    m_start(); m_wbyte({7'h11, 1'b0}, ack);
    chk("R2 mismatch no ack", ack, 0);
    chk("R2 mismatch no hold", scl_oe, 0);
    m_stop();

    // R3 R4 programmed address, write direction
    h_write(2'd0, {1'b0, MY_ADDR});
    m_start(); m_wbyte({MY_ADDR, 1'b0}, ack);
    chk("R3 address ack", ack, 1);
    chk("R4 hold after address ack", scl_oe, 1);
    h_read(2'd2, rd); chk("R3 status write dir", rd, 8'h22);
    h_read(2'd1, rd);
    chk("R4 released after service", scl_oe, 0);

    // R5 table of received bytes
    for (int i = 0; i < 5; i++) begin
      m_wbyte(RX_VEC[i][15:8], ack);
      chk("R5 data ack", ack, 1);
      chk("R4 hold after data ack", scl_oe, 1);
      h_read(2'd2, rd); chk("R5 status", rd, RX_VEC[i][7:0]);
      h_read(2'd1, rd); chk("R5 data", rd, RX_VEC[i][15:8]);
      chk("R5 released by read", scl_oe, 0);
    end

    // R12 release command, R6 R7 overrun
    m_wbyte(8'h11, ack);
    h_write(2'd2, 8'h80);
    chk("R12 go releases", scl_oe, 0);
    h_read(2'd2, rd); chk("R12 buffer full kept", rd, 8'h14);
    m_wbyte(8'h22, ack);
    chk("R7 ack after overrun", ack, 1);
    chk("R7 hold after overrun", scl_oe, 1);
    h_read(2'd2, rd); chk("R6 overrun set", rd, 8'h3C);
    h_read(2'd1, rd); chk("R6 overwritten", rd, 8'h22);
    h_write(2'd2, 8'h00);
    h_read(2'd2, rd); chk("R8 write 0 keeps overrun", rd, 8'h0C);
    h_write(2'd3, 8'h02);
    chk("R11 overrun irq", irq, 1);
    h_write(2'd2, 8'h08);
    h_read(2'd2, rd); chk("R8 write 1 clears", rd, 8'h04);
    chk("R11 irq drops", irq, 0);

    // R9 stop mid-byte
    m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
    m_stop();
    h_read(2'd2, rd); chk("R9 stop code", rd, 8'h01);
    h_read(2'd1, rd); chk("R9 buffer unchanged", rd, 8'h22);
    chk("R9 scl released", scl_oe, 0);
    chk("R9 sda released", sda_oe, 0);

    // R10 R11 read direction
    h_write(2'd3, 8'h01);
    chk("R11 no pending event", irq, 0);
    m_start(); m_wbyte({MY_ADDR, 1'b1}, ack);
    chk("R3 read dir ack", ack, 1);
    chk("R11 event irq", irq, 1);
    h_read(2'd2, rd); chk("R3 status read dir", rd, 8'h23);
    chk("R11 cleared by status read", irq, 0);
    h_write(2'd3, 8'h00);
    h_write(2'd1, 8'hA5);
    chk("R10 released by write", scl_oe, 0);
    m_rbyte(rd, 1'b0); chk("R10 sent byte", rd, 8'hA5);
    chk("R10 hold after master ack", scl_oe, 1);
    h_read(2'd2, rd); chk("R10 ack status", rd, 8'h25);
    h_write(2'd1, 8'h3C);
    m_rbyte(rd, 1'b1); chk("R10 second byte", rd, 8'h3C);
    chk("R10 no hold on nack", scl_oe, 0);
    chk("R10 sda free on nack", sda_oe, 0);
    h_read(2'd2, rd); chk("R10 nack status", rd, 8'h06);
    m_stop();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule